// File: doc/BRIEF.md
# Repeater Port Security Data Gate

This block sits in the data path of a multi-port repeater. For every received packet it decides whether the real bytes are forwarded or replaced by pseudo-random bytes. It makes that choice separately for the two destinations of the repeated stream: the local transmitting ports and the expansion bus that links several repeater chips. The choice depends on three registered configuration bits and on two match flags from an external address comparator. The bits are a security enable, a source-address-check enable and a destination-address-check enable. The match flags report whether the packet's source and destination addresses were found.

The packet stream is byte-wide with `valid_i`, `sop_i` and `eop_i` strobes. An external `decide_i` pulse marks the cycle in which the comparator's flags are valid. From the byte after that pulse until the end of the packet, each lane carries the original byte or a byte from an internal 16-bit LFSR. A source failure garbles both lanes. A destination failure garbles only the local ports. The expansion bus then keeps the real data so that the other chips can apply their own checks.

Top module: `sec_data_gate`

## Requirements
- R1: While rst_ni is low and after its release with no input activity, port_valid_o and bus_valid_o are 0 and port_data_o and bus_data_o are 8'h00.
- R2: With the registered security enable at 0, both lanes forward every byte unchanged, whatever the check enables and match flags are.
- R3: With security enabled and both check enables at 0, both lanes forward every byte unchanged.
- R4: With security enabled, destination checking enabled, and no source failure, a destination mismatch (da_match_i=0) randomizes the port lane only. A destination match forwards both lanes unchanged.
- R5: With security and source checking enabled, a source mismatch (sa_match_i=0) randomizes both lanes, whatever the destination result.
- R6: With security and source checking enabled, destination checking off and a source match, both lanes forward unchanged whatever da_match_i is.
- R7: With both checks enabled, a source match together with a destination match forwards both lanes unchanged.
- R8: Match flags are sampled only on the first decide_i pulse of a packet. Bytes up to and including the one presented with that pulse are forwarded unchanged, and substitution begins with the next byte. Later decide_i pulses and flag changes within the packet have no effect.
- R9: The choice is cleared after the byte presented with eop_i, so the next packet forwards unchanged until its own decision.
- R10: The configuration bits are captured on the byte presented with sop_i. Changes at any other time affect only a later packet.
- R11: The random byte is bits [7:0] of a 16-bit LFSR seeded to 16'hACE1. On every valid input byte, used or not, the LFSR advances as next = (s >> 1) ^ (s[0] ? 16'hB400 : 16'h0000). The byte uses the value held before that advance.
- R12: Each output lane is registered. A byte presented with valid_i at one rising edge appears with its lane valid on the following cycle. A cycle without valid_i gives a low lane valid on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sec_en_i | input | 1 | Security enable, captured at packet start |
| sa_chk_i | input | 1 | Source-address check enable, captured at packet start |
| da_chk_i | input | 1 | Destination-address check enable, captured at packet start |
| sa_match_i | input | 1 | Source address matched, sampled on decide |
| da_match_i | input | 1 | Destination address matched, sampled on decide |
| decide_i | input | 1 | Address fields received, match flags valid |
| valid_i | input | 1 | Input byte valid |
| sop_i | input | 1 | First byte of packet |
| eop_i | input | 1 | Last byte of packet |
| data_i | input | 8 | Input packet byte |
| port_valid_o | output | 1 | Local-port lane byte valid |
| port_data_o | output | 8 | Local-port lane byte |
| bus_valid_o | output | 1 | Expansion-bus lane byte valid |
| bus_data_o | output | 8 | Expansion-bus lane byte |

## Verification
Every lane result is due exactly one cycle after the byte that produced it. The bench drives each byte on a falling edge and reads both lanes on the next falling edge, so each check sees the register loaded by the single rising edge between them. A decision is visible only from the byte after the decide pulse, which is two falling edges later. The bench tracks this by byte index within the packet. Its own LFSR model advances once per valid byte it sends, so the expected random value is fixed for each sampled byte.

// File: rtl/sec_gate_pkg.sv
package sec_gate_pkg;
  typedef struct packed {
    logic sec_en;
    logic sa_chk;
    logic da_chk;
  } sec_cfg_t;

  typedef struct packed {
    logic rand_port;
    logic rand_bus;
  } gate_sel_t;

  localparam int unsigned NUM_LANES = 2;
  localparam int unsigned LANE_PORT = 0;
  localparam int unsigned LANE_BUS  = 1;
endpackage

// File: rtl/sec_gate_lfsr.sv
module sec_gate_lfsr #(
  parameter int unsigned      LFSR_W = 16,
  parameter int unsigned      OUT_W  = 8,
  parameter logic [LFSR_W-1:0] SEED  = 16'hACE1,
  parameter logic [LFSR_W-1:0] MASK  = 16'hB400
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  output logic [OUT_W-1:0] rnd_o
);
  logic [LFSR_W-1:0] state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     state_q <= SEED;
    else if (step_i) state_q <= (state_q >> 1) ^ (state_q[0] ? MASK : '0);
  end

  assign rnd_o = state_q[OUT_W-1:0];

  assert_lfsr_live_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != '0);
  assert_lfsr_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(state_q));
endmodule

// File: rtl/sec_gate_ctrl.sv
module sec_gate_ctrl
  import sec_gate_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  sec_cfg_t  cfg_i,
  input  logic      sa_match_i,
  input  logic      da_match_i,
  input  logic      decide_i,
  input  logic      valid_i,
  input  logic      sop_i,
  input  logic      eop_i,
  output gate_sel_t sel_o
);
  sec_cfg_t  cfg_q;
  gate_sel_t sel_q, sel_d;
  logic      in_pkt_q, decided_q;
  logic      pkt_start, pkt_end, take;

  assign pkt_start = valid_i & sop_i;
  assign pkt_end   = valid_i & eop_i;
  assign take      = decide_i & in_pkt_q & ~decided_q;

  // source failure hits both lanes; destination failure only the local ports
  always_comb begin
    sel_d = '0;
    if (cfg_q.sec_en) begin
      if (cfg_q.sa_chk && !sa_match_i) begin
        sel_d.rand_port = 1'b1;
        sel_d.rand_bus  = 1'b1;
      end else if (cfg_q.da_chk && !da_match_i) begin
        sel_d.rand_port = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q     <= '0;
      in_pkt_q  <= 1'b0;
      decided_q <= 1'b0;
      sel_q     <= '0;
    end else begin
      if (pkt_start) cfg_q <= cfg_i;
      if (pkt_end) begin
        in_pkt_q  <= 1'b0;
        decided_q <= 1'b0;
        sel_q     <= '0;
      end else begin
        if (pkt_start) in_pkt_q <= 1'b1;
        if (take) begin
          decided_q <= 1'b1;
          sel_q     <= sel_d;
        end
      end
    end
  end

  assign sel_o = sel_q;

  assert_bus_implies_port_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_q.rand_bus |-> sel_q.rand_port);
  assert_clear_at_end_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_end |=> sel_q == '0);
  assert_hold_after_decide_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (decided_q && !pkt_end) |=> $stable(sel_q));
  assert_cfg_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pkt_start |=> $stable(cfg_q));
endmodule

// File: rtl/sec_gate_lane.sv
module sec_gate_lane #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [DATA_W-1:0] rnd_i,
  input  logic              sub_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) data_o <= sub_i ? rnd_i : data_i;
    end
  end

  assert_valid_latency_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  assert_idle_latency_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
endmodule

// File: rtl/sec_data_gate.sv
module sec_data_gate
  import sec_gate_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned LFSR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sec_en_i,
  input  logic              sa_chk_i,
  input  logic              da_chk_i,
  input  logic              sa_match_i,
  input  logic              da_match_i,
  input  logic              decide_i,
  input  logic              valid_i,
  input  logic              sop_i,
  input  logic              eop_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              port_valid_o,
  output logic [DATA_W-1:0] port_data_o,
  output logic              bus_valid_o,
  output logic [DATA_W-1:0] bus_data_o
);
  sec_cfg_t              cfg;
  gate_sel_t             sel;
  logic [DATA_W-1:0]     rnd;
  logic [NUM_LANES-1:0]  sub;
  logic [NUM_LANES-1:0]  lane_valid;
  logic [DATA_W-1:0]     lane_data [NUM_LANES];

  assign cfg = '{sec_en: sec_en_i, sa_chk: sa_chk_i, da_chk: da_chk_i};

  sec_gate_lfsr #(.LFSR_W(LFSR_W), .OUT_W(DATA_W)) u_lfsr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .step_i(valid_i),
    .rnd_o (rnd)
  );

  sec_gate_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cfg_i     (cfg),
    .sa_match_i(sa_match_i),
    .da_match_i(da_match_i),
    .decide_i  (decide_i),
    .valid_i   (valid_i),
    .sop_i     (sop_i),
    .eop_i     (eop_i),
    .sel_o     (sel)
  );

  assign sub[LANE_PORT] = sel.rand_port;
  assign sub[LANE_BUS]  = sel.rand_bus;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    sec_gate_lane #(.DATA_W(DATA_W)) u_lane (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .valid_i(valid_i),
      .data_i (data_i),
      .rnd_i  (rnd),
      .sub_i  (sub[g]),
      .valid_o(lane_valid[g]),
      .data_o (lane_data[g])
    );
  end

  assign port_valid_o = lane_valid[LANE_PORT];
  assign port_data_o  = lane_data[LANE_PORT];
  assign bus_valid_o  = lane_valid[LANE_BUS];
  assign bus_data_o   = lane_data[LANE_BUS];

  assert_lanes_aligned_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    port_valid_o == bus_valid_o);
endmodule

// File: tb/tb_sec_data_gate.sv
module tb_sec_data_gate;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sec_en = 0, sa_chk = 0, da_chk = 0, sa_m = 0, da_m = 0;
  logic       decide = 0, valid = 0, sop = 0, eop = 0;
  logic [7:0] data = '0;
  logic       port_valid, bus_valid;
  logic [7:0] port_data, bus_data;
  int         errors = 0;
  int         checks = 0;
  logic [15:0] lfsr_m = 16'hACE1;

  always #10 clk = ~clk;  // 50 MHz

  sec_data_gate dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .sec_en_i(sec_en), .sa_chk_i(sa_chk), .da_chk_i(da_chk),
    .sa_match_i(sa_m), .da_match_i(da_m), .decide_i(decide),
    .valid_i(valid), .sop_i(sop), .eop_i(eop), .data_i(data),
    .port_valid_o(port_valid), .port_data_o(port_data),
    .bus_valid_o(bus_valid), .bus_data_o(bus_data)
  );

  // [6]sec [5]sa_chk [4]da_chk [3]sa_m [2]da_m [1]port rand [0]bus rand
  localparam logic [6:0] VEC [12] = '{
    7'b0110000, 7'b0011000, 7'b1000000, 7'b1011010,
    7'b1010100, 7'b1100111, 7'b1110111, 7'b1101000,
    7'b1111100, 7'b1111010, 7'b1110011, 7'b1101100
  };

  function automatic string row_req(int i);
    case (i)
      0, 1:     return "R2";
      2:        return "R3";
      3, 4, 9:  return "R4";
      5, 6, 10: return "R5";
      7, 11:    return "R6";
      default:  return "R7";
    endcase
  endfunction

  task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // drive one byte on a falling edge, check both lanes one cycle later
  task automatic send_byte(logic [7:0] d, logic s, logic e, logic dec,
                           logic exp_p, logic exp_b, string req);
    logic [7:0] r;
    data = d; sop = s; eop = e; decide = dec; valid = 1'b1;
    r = lfsr_m[7:0];
    lfsr_m = (lfsr_m >> 1) ^ (lfsr_m[0] ? 16'hB400 : 16'h0000);
    @(posedge clk);
    @(negedge clk);
    valid = 1'b0; sop = 1'b0; eop = 1'b0; decide = 1'b0;
    chk("R12", "port valid", {7'd0, port_valid}, 8'd1);
    chk("R12", "bus valid",  {7'd0, bus_valid},  8'd1);
    chk(req, "port data", port_data, exp_p ? r : d);
    chk(req, "bus data",  bus_data,  exp_b ? r : d);
  endtask

  task automatic idle_cycle();
    @(posedge clk);
    @(negedge clk);
    chk("R12", "idle port valid", {7'd0, port_valid}, 8'd0);
    chk("R12", "idle bus valid",  {7'd0, bus_valid},  8'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "port valid in reset", {7'd0, port_valid}, 8'd0);
    chk("R1", "port data in reset",  port_data, 8'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1", "bus valid after reset", {7'd0, bus_valid}, 8'd0);
    chk("R1", "bus data after reset",  bus_data, 8'd0);

    for (int i = 0; i < 12; i++) begin
      {sec_en, sa_chk, da_chk} = VEC[i][6:4];
      send_byte(8'h10 + 8'(i), 1, 0, 0, 0, 0, "R8");
      {sa_m, da_m} = VEC[i][3:2];
      send_byte(8'h20 + 8'(i), 0, 0, 0, 0, 0, "R8");
      send_byte(8'h30 + 8'(i), 0, 0, 1, 0, 0, "R8");
      for (int k = 3; k < 6; k++)
        send_byte(8'(k * 16) + 8'(i), 0, k == 5, 0, VEC[i][1], VEC[i][0], row_req(i));
      idle_cycle();
    end

    // R10: config change after sop has no effect on this packet
    {sec_en, sa_chk, da_chk} = 3'b000;
    send_byte(8'hA0, 1, 0, 0, 0, 0, "R10");
    {sec_en, sa_chk, da_chk} = 3'b110; sa_m = 0; da_m = 1;
    send_byte(8'hA1, 0, 0, 1, 0, 0, "R10");
    send_byte(8'hA2, 0, 0, 0, 0, 0, "R10");
    send_byte(8'hA3, 0, 1, 0, 0, 0, "R10");
    // R10: next packet takes the new config
    send_byte(8'hB0, 1, 0, 0, 0, 0, "R10");
    send_byte(8'hB1, 0, 0, 1, 0, 0, "R8");
    send_byte(8'hB2, 0, 0, 0, 1, 1, "R10");
    send_byte(8'hB3, 0, 1, 0, 1, 1, "R10");
    // R9: after a randomized packet, the next starts unchanged
    {sec_en, sa_chk, da_chk} = 3'b101; sa_m = 1; da_m = 1;
    send_byte(8'hC0, 1, 0, 0, 0, 0, "R9");
    send_byte(8'hC1, 0, 0, 0, 0, 0, "R9");
    // R8: first decide wins; a later decide with mismatch is ignored
    send_byte(8'hC2, 0, 0, 1, 0, 0, "R8");
    da_m = 0;
    send_byte(8'hC3, 0, 0, 1, 0, 0, "R8");
    send_byte(8'hC4, 0, 1, 0, 0, 0, "R8");
    idle_cycle();
    // R4: decide in mid-packet, substitution from the following byte only
    send_byte(8'hD0, 1, 0, 0, 0, 0, "R8");
    send_byte(8'hD1, 0, 0, 1, 0, 0, "R8");
    send_byte(8'hD2, 0, 0, 0, 1, 0, "R4");
    // R11: LFSR advances on the unused idle-free stream too
    send_byte(8'hD3, 0, 1, 0, 1, 0, "R11");
    idle_cycle();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule